// File: doc/BRIEF.md
# Serial Peripheral Controller with Overflow and Mode-Fault Flags

The block is an 8-bit synchronous serial port that a CPU runs through two registers. Writes to the data address go into a one-entry transmit holding buffer. The buffer feeds a shift register, so software can queue a second byte while the first one is still shifting. A completed byte moves into a receive data register and sets a receive-full flag. Serial timing is fixed: clock idle low, input sampled on the rising edge, output changed on the falling edge, most significant bit first. As master, the block makes the serial clock by dividing the bus clock by two.

The block has two error flags. Overflow sets when the receive register is still unread at the seventh sampling edge of the next byte. From then on, every received byte is discarded until software reads status and then reads data. Mode fault sets when a master sees its select input pulled low. The port then falls back to slave, stops driving clock and data, and stays that way until software reads status and then writes control. One interrupt line merges receive-full and the two error flags, each source gated by its own enable.

Top module: `spi_err_ctrl`

## Requirements
- R1: Address 0 reads the status byte {bit7 rx_full, bit6 overflow, bit5 mode_fault, bit4 tx_empty, bit3 0, bit2 rx_ie, bit1 err_ie, bit0 master}. A write to address 0 loads rx_ie, err_ie and master from bits 2..0. Address 1 is the data register. After reset the status byte reads 0x10, and no clock, MOSI or MISO output is enabled.
- R2: A data write while tx_empty=1 fills the transmit buffer and clears tx_empty. A data write while tx_empty=0 is ignored and leaves the queued byte intact.
- R3: When the shift register is idle, the buffer moves into it one cycle after the write, and tx_empty reads 1 again by the second cycle. A slave that is mid-byte keeps a new buffered byte (tx_empty=0) until the current byte ends, then sends it next.
- R4: As master, sck_o toggles every bus cycle during a byte and idles low. One byte is 8 rising edges, with mosi_o stable at each rising edge, most significant bit first.
- R5: As slave with ss_ni low, the block samples mosi_i on rising sck_i and updates miso_o after falling sck_i. miso_oe_o is high only while it is a selected slave.
- R6: A completed byte that arrives while overflow=0 is written to the data register and sets rx_full. A data read clears rx_full.
- R7: Overflow sets at the 7th rising sample edge of a byte if rx_full is still 1, and not before.
- R8: While overflow=1, completed bytes are discarded. The data register keeps its earlier byte and rx_full does not set.
- R9: Overflow clears only after a status read that sees it set, followed by a data read. A data read alone leaves it set.
- R10: A master whose synchronised ss_ni goes low sets mode_fault and clears master. sck_oe_o and mosi_oe_o go low.
- R11: Mode_fault clears only after a status read that sees it set, followed by a control write. While it is set, other control writes cannot set master.
- R12: irq_o = (err_ie AND (overflow OR mode_fault)) OR (rx_ie AND rx_full).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 1 | 0 = status/control, 1 = data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (triggers read side effects) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected address |
| irq_o | output | 1 | Combined receive/error interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_ni | input | 1 | Select input, active low |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_i | input | 1 | Serial data in (master) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Enable for sck_o |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe_o | output | 1 | Enable for mosi_o |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe_o | output | 1 | Enable for miso_o |

## Verification
The assertions check these rules on every cycle:
- tx_empty clears after an accepted write and refills after a load.
- A write into a full buffer leaves the queued byte untouched.
- Overflow rises only where a bit-1 strobe meets a full receive register.
- While overflow is set, the receive register never changes.
- Both error flags hold until their own clearing access.
- Output enables stay low while a mode fault is set.

The bench scenarios show what a per-cycle property cannot:
- the exact sampling edge at which overflow sets;
- the bit order and edge count on the wire;
- a queued byte following its predecessor on the wire;
- the two-step clear sequences, taken in the right and in the wrong order.

// File: rtl/spi_err_pkg.sv
package spi_err_pkg;
  localparam int unsigned ST_RXF  = 7;
  localparam int unsigned ST_OVR  = 6;
  localparam int unsigned ST_MODF = 5;
  localparam int unsigned ST_TXE  = 4;
  localparam int unsigned CT_RXIE = 2;
  localparam int unsigned CT_ERRIE = 1;
  localparam int unsigned CT_MSTR = 0;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/spi_err_sync.sv
module spi_err_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) q[i] <= RST_VAL;
    end else begin
      q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) q[i] <= q[i-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/spi_err_shifter.sv
module spi_err_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              ss_act_i,
  input  logic              sck_s_i,
  input  logic              sin_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              idle_o,
  output logic              bit1_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sout_o,
  output logic              sck_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] BIT1 = CNT_W'(DATA_W - 2);

  logic [DATA_W-1:0] sh_q;
  logic              cap_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              run_q, sck_q, sck_d_q, mode_d_q;
  logic              sample, shift;

  // master: sck_q low -> rising next, high -> falling next
  assign sample = (master_i & run_q & ~sck_q) |
                  (~master_i & ss_act_i & sck_s_i & ~sck_d_q);
  assign shift  = (master_i & run_q & sck_q) |
                  (~master_i & ss_act_i & ~sck_s_i & sck_d_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cap_q    <= 1'b0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      sck_q    <= 1'b0;
      sck_d_q  <= 1'b0;
      mode_d_q <= 1'b0;
    end else begin
      sck_d_q  <= sck_s_i;
      mode_d_q <= master_i;
      if (run_q) sck_q <= ~sck_q;
      if (sample) begin
        cap_q <= sin_i;
        cnt_q <= cnt_q + 1'b1;
      end
      if (shift) begin
        sh_q <= {sh_q[DATA_W-2:0], cap_q};
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end
      end
      if (load_i) begin
        sh_q  <= load_data_i;
        run_q <= master_i;
      end
      // deselect or mode change aborts a partial byte
      if ((!master_i && !ss_act_i) || (master_i != mode_d_q)) cnt_q <= '0;
      if (!master_i) begin
        run_q <= 1'b0;
        sck_q <= 1'b0;
      end
    end
  end

  assign idle_o    = ~run_q & (cnt_q == '0);
  assign bit1_o    = sample & (cnt_q == BIT1);
  assign done_o    = shift & (cnt_q == LAST);
  assign rx_byte_o = {sh_q[DATA_W-2:0], cap_q};
  assign sout_o    = sh_q[DATA_W-1];
  assign sck_o     = sck_q;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_sck_idle_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !sck_q);
endmodule

// File: rtl/spi_err_ctrl.sv
module spi_err_ctrl
  import spi_err_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  logic [2:0]        sync_q;
  logic              ss_s, sck_s, mosi_s;
  logic [DATA_W-1:0] txbuf_q, rdr_q, rx_byte, status;
  logic              txe_q, rxf_q, ovr_q, modf_q, ovr_arm_q, modf_arm_q;
  logic              master_q, err_ie_q, rx_ie_q;
  logic              sh_idle, sh_bit1, sh_done, sh_sout, sh_sck;
  logic              wr_ctrl, wr_data, rd_ctrl, rd_data, load, modf_set;

  spi_err_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sck_i, mosi_i}),
    .q_o   (sync_q)
  );
  assign {ss_s, sck_s, mosi_s} = sync_q;

  assign wr_ctrl  = reg_wr_i & (reg_addr_i == ADDR_CTRL);
  assign wr_data  = reg_wr_i & (reg_addr_i == ADDR_DATA);
  assign rd_ctrl  = reg_rd_i & (reg_addr_i == ADDR_CTRL);
  assign rd_data  = reg_rd_i & (reg_addr_i == ADDR_DATA);
  assign load     = ~txe_q & sh_idle;
  assign modf_set = master_q & ~ss_s;

  spi_err_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .master_i   (master_q),
    .ss_act_i   (~ss_s),
    .sck_s_i    (sck_s),
    .sin_i      (master_q ? miso_i : mosi_s),
    .load_i     (load),
    .load_data_i(txbuf_q),
    .idle_o     (sh_idle),
    .bit1_o     (sh_bit1),
    .done_o     (sh_done),
    .rx_byte_o  (rx_byte),
    .sout_o     (sh_sout),
    .sck_o      (sh_sck)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txbuf_q    <= '0;
      txe_q      <= 1'b1;
      rdr_q      <= '0;
      rxf_q      <= 1'b0;
      ovr_q      <= 1'b0;
      ovr_arm_q  <= 1'b0;
      modf_q     <= 1'b0;
      modf_arm_q <= 1'b0;
      master_q   <= 1'b0;
      err_ie_q   <= 1'b0;
      rx_ie_q    <= 1'b0;
    end else begin
      if (wr_data && txe_q) begin
        txbuf_q <= reg_wdata_i;
        txe_q   <= 1'b0;
      end else if (load) begin
        txe_q <= 1'b1;
      end

      if (sh_done && !ovr_q) rdr_q <= rx_byte;
      if (sh_done && !ovr_q) rxf_q <= 1'b1;
      else if (rd_data)      rxf_q <= 1'b0;

      // overflow: set at bit-1 strobe, clear by status read then data read
      if (sh_bit1 && rxf_q)          ovr_q <= 1'b1;
      else if (rd_data && ovr_arm_q) ovr_q <= 1'b0;
      if (rd_ctrl && ovr_q) ovr_arm_q <= 1'b1;
      else if (rd_data)     ovr_arm_q <= 1'b0;

      if (modf_set)                    modf_q <= 1'b1;
      else if (wr_ctrl && modf_arm_q)  modf_q <= 1'b0;
      if (rd_ctrl && modf_q) modf_arm_q <= 1'b1;
      else if (wr_ctrl)      modf_arm_q <= 1'b0;

      if (wr_ctrl) begin
        err_ie_q <= reg_wdata_i[CT_ERRIE];
        rx_ie_q  <= reg_wdata_i[CT_RXIE];
      end
      if (modf_set) master_q <= 1'b0;
      else if (wr_ctrl && (!modf_q || modf_arm_q)) master_q <= reg_wdata_i[CT_MSTR];
    end
  end

  always_comb begin
    status           = '0;
    status[ST_RXF]   = rxf_q;
    status[ST_OVR]   = ovr_q;
    status[ST_MODF]  = modf_q;
    status[ST_TXE]   = txe_q;
    status[CT_RXIE]  = rx_ie_q;
    status[CT_ERRIE] = err_ie_q;
    status[CT_MSTR]  = master_q;
  end

  assign reg_rdata_o = (reg_addr_i == ADDR_DATA) ? rdr_q : status;
  assign irq_o       = (err_ie_q & (ovr_q | modf_q)) | (rx_ie_q & rxf_q);
  assign sck_o       = sh_sck & master_q;
  assign sck_oe_o    = master_q;
  assign mosi_o      = sh_sout;
  assign mosi_oe_o   = master_q;
  assign miso_o      = sh_sout;
  assign miso_oe_o   = ~master_q & ~ss_s;

  p_txe_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && txe_q) |=> !txe_q);
  p_full_write_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && !txe_q) |=> $stable(txbuf_q));
  p_txe_refill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> txe_q);
  p_rxf_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_done && !ovr_q) |=> rxf_q);
  p_ovr_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(sh_bit1 && rxf_q));
  p_ovr_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> $stable(rdr_q));
  p_ovr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !rd_data) |=> ovr_q);
  p_modf_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    modf_q |-> (!sck_oe_o && !mosi_oe_o));
  p_modf_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modf_q && !wr_ctrl) |=> modf_q);
  p_irq_gated_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_ie_q && !rx_ie_q) |-> !irq_o);
endmodule

// File: tb/tb_spi_err_ctrl.sv
module tb_spi_err_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       irq;
  logic       sck_drv = 1'b0, ss_drv = 1'b1, mosi_drv = 1'b0;
  logic       miso_i;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  int         checks = 0, errors = 0;
  int         mon_cnt = 0;
  logic [15:0] mon_bits = '0;

  always #5 clk = ~clk;

  assign miso_i = mosi_o;  // loopback in master mode

  spi_err_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .sck_i(sck_drv), .ss_ni(ss_drv), .mosi_i(mosi_drv), .miso_i(miso_i),
    .sck_o(sck_o), .sck_oe_o(sck_oe), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe),
    .miso_o(miso_o), .miso_oe_o(miso_oe)
  );

  always @(posedge sck_o) begin
    mon_bits <= {mon_bits[14:0], mosi_o};
    mon_cnt  <= mon_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_rxf();
    logic [7:0] st;
    for (int i = 0; i < 400; i++) begin
      peek(1'b0, st);
      if (st[7]) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] st;
    peek(1'b0, st);
    check("R1 reset status", st, 8'h10);
    check("R1 reset oe", {sck_oe, mosi_oe, miso_oe}, 3'b000);
    check("R12 reset irq", irq, 1'b0);
  endtask

  task automatic t_master_single();
    logic [7:0] st, d;
    int base;
    cpu_wr(1'b0, 8'h03);
    peek(1'b0, st);
    check("R1 ctrl readback", st, 8'h13);
    check("R10 master oe", {sck_oe, mosi_oe}, 2'b11);
    base = mon_cnt;
    cpu_wr(1'b1, 8'hA5);
    peek(1'b0, st);
    check("R3 txe refill", st[4], 1'b1);
    wait_rxf();
    check("R4 edge count", mon_cnt - base, 8);
    check("R4 msb first", mon_bits[7:0], 8'hA5);
    check("R4 sck idle low", sck_o, 1'b0);
    cpu_rd(1'b1, d);
    check("R6 rx data", d, 8'hA5);
    peek(1'b0, st);
    check("R6 rxf cleared", st[7], 1'b0);
  endtask

  task automatic t_queue_overflow();
    logic [7:0] st, d;
    int base;
    base = mon_cnt;
    cpu_wr(1'b1, 8'h3C);
    cpu_wr(1'b1, 8'hC3);
    cpu_wr(1'b1, 8'h77);
    peek(1'b0, st);
    check("R2 full buffer", st[4], 1'b0);
    wait (mon_cnt == base + 14);
    peek(1'b0, st);
    check("R7 no ovr at 6th edge", st[6], 1'b0);
    wait (mon_cnt == base + 15);
    peek(1'b0, st);
    check("R7 ovr at 7th edge", st[6], 1'b1);
    check("R12 irq on ovr", irq, 1'b1);
    wait (mon_cnt == base + 16);
    repeat (4) @(negedge clk);
    check("R2 R3 queued order", mon_bits, 16'h3CC3);
    peek(1'b1, d);
    check("R8 old byte kept", d, 8'h3C);
    cpu_wr(1'b0, 8'h01);
    check("R12 irq masked", irq, 1'b0);
    cpu_wr(1'b0, 8'h03);
    cpu_rd(1'b1, d);
    check("R8 read old byte", d, 8'h3C);
    peek(1'b0, st);
    check("R9 data read alone keeps ovr", st[6], 1'b1);
    cpu_wr(1'b1, 8'h5A);
    repeat (40) @(negedge clk);
    peek(1'b0, st);
    check("R8 dropped no rxf", st[7], 1'b0);
    peek(1'b1, d);
    check("R8 dropped data", d, 8'h3C);
    cpu_rd(1'b0, st);
    cpu_rd(1'b1, d);
    peek(1'b0, st);
    check("R9 ovr cleared", st[6], 1'b0);
    cpu_wr(1'b1, 8'h96);
    wait_rxf();
    cpu_rd(1'b1, d);
    check("R6 after clear", d, 8'h96);
  endtask

  task automatic slave_xfer(input logic [7:0] mo, output logic [7:0] mi,
                            input bit queue, input logic [7:0] qd);
    logic [7:0] st;
    for (int i = 7; i >= 0; i--) begin
      mosi_drv = mo[i];
      repeat (8) @(negedge clk);
      sck_drv = 1'b1;
      mi[i] = miso_o;
      if (queue && i == 5) begin
        cpu_wr(1'b1, qd);
        repeat (6) @(negedge clk);
      end else if (queue && i == 2) begin
        peek(1'b0, st);
        check("R3 slave holds buffer", st[4], 1'b0);
        repeat (7) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      sck_drv = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic t_slave();
    logic [7:0] st, d, mi;
    cpu_wr(1'b0, 8'h04);
    ss_drv = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 miso oe selected", miso_oe, 1'b1);
    check("R5 sck oe off", sck_oe, 1'b0);
    cpu_wr(1'b1, 8'h81);
    peek(1'b0, st);
    check("R3 slave idle load", st[4], 1'b1);
    slave_xfer(8'h6E, mi, 1'b1, 8'h42);
    check("R5 slave out", mi, 8'h81);
    check("R12 rx irq", irq, 1'b1);
    peek(1'b0, st);
    check("R3 load after byte", st[4], 1'b1);
    cpu_rd(1'b1, d);
    check("R5 R6 slave in", d, 8'h6E);
    check("R12 irq after read", irq, 1'b0);
    slave_xfer(8'h00, mi, 1'b0, 8'h00);
    check("R3 queued slave byte", mi, 8'h42);
    cpu_rd(1'b1, d);
    check("R5 second slave in", d, 8'h00);
    ss_drv = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 miso oe deselected", miso_oe, 1'b0);
  endtask

  task automatic t_modf();
    logic [7:0] st;
    cpu_wr(1'b0, 8'h03);
    check("R10 master before fault", sck_oe, 1'b1);
    ss_drv = 1'b0;
    repeat (5) @(negedge clk);
    peek(1'b0, st);
    check("R10 modf set", st[5], 1'b1);
    check("R10 master cleared", st[0], 1'b0);
    check("R10 outputs off", {sck_oe, mosi_oe}, 2'b00);
    check("R12 irq on modf", irq, 1'b1);
    ss_drv = 1'b1;
    repeat (4) @(negedge clk);
    cpu_wr(1'b0, 8'h03);
    peek(1'b0, st);
    check("R11 write alone keeps modf", st[5], 1'b1);
    check("R11 master still off", st[0], 1'b0);
    cpu_rd(1'b0, st);
    cpu_wr(1'b0, 8'h03);
    peek(1'b0, st);
    check("R11 modf cleared", st[5], 1'b0);
    check("R11 master restored", st[0], 1'b1);
    check("R11 sck oe back", sck_oe, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_master_single();
    t_queue_overflow();
    t_slave();
    t_modf();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule